// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Unit

This block holds the interrupt state of a single processor. It keeps a current priority, one pending source with its priority, and a slot for an inter-processor interrupt (IPI). It drives one interrupt line toward the processor.

The source unit offers interrupts to the block. The processor sends four commands: set the current priority, set the IPI priority, accept the pending interrupt, and end-of-interrupt. An interrupt that the block refuses or displaces goes back to the source unit on a reject strobe. When the processor can take more work, the block asks the source unit to replay held interrupts through a resend strobe. End-of-interrupt is passed on as an EOI strobe that carries the source number.

Priorities follow one rule: a lower value is more favoured, and 0xFF means least favoured or none. Only one operation arrives per cycle, on a single opcode/data port.

Top module: `cpu_irq_presenter`

## Requirements
- R1: After reset, `pend_word` is 0, `ipi_prio` is 0xFF, the internal pending priority is 0xFF, `irq_out` is low and every strobe is low. The current priority is `pend_word[31:24]` and the pending source is `pend_word[23:0]`, where source 0 means nothing is pending.
- R2: An offer (`cmd_op`=1, `cmd_data`={priority[31:24], source[23:0]}) is refused when its priority is greater than or equal to the current priority. The refused source number is reported on `rej_src`, and the state is left unchanged.
- R3: An offer is also refused when a source is already pending whose priority is less than or equal to the offered priority.
- R4: An offer that is not refused takes the pending slot. Any displaced source is rejected, the new source and priority are latched, and `irq_out` goes high.
- R5: Setting the IPI priority (`cmd_op`=3, value in `cmd_data[7:0]`) stores it. If the value is below the current priority, an IPI check runs. The check rejects any pending source, loads source number 2 with the IPI priority, and raises `irq_out`.
- R6: The IPI check changes nothing when a source is pending whose priority is less than or equal to the IPI priority.
- R7: Accept (`cmd_op`=4) returns the whole pending word on `acc_word` with `acc_valid` set. It then lowers `irq_out`, moves the pending priority into the current-priority field, clears the source field and sets the pending priority to 0xFF.
- R8: Setting the current priority (`cmd_op`=2, value in `cmd_data[7:0]`) to a lower value stores it. If a source is pending and the new value is at or below that source's priority, the source is cleared and rejected, and `irq_out` drops. Otherwise the pending source stays.
- R9: Setting the current priority to a value greater than or equal to the old one, with nothing pending, raises `resend_req`. Before that, it runs the IPI check if the IPI priority is below the new current priority.
- R10: End-of-interrupt (`cmd_op`=5) copies `cmd_data[31:24]` into the current priority and sends `cmd_data[23:0]` on `eoi_src` with `eoi_valid`. If nothing is pending, it also raises `resend_req` and first runs the IPI check when the IPI priority is below the new current priority.
- R11: Every output reflects a command one clock after that command. The strobes `rej_valid`, `resend_req`, `eoi_valid` and `acc_valid` last a single cycle. Opcode 0 is idle and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | 0 idle, 1 offer, 2 set current priority, 3 set IPI priority, 4 accept, 5 end-of-interrupt |
| cmd_data | input | 32 | Operand of the command |
| irq_out | output | 1 | Interrupt line to the processor |
| pend_word | output | 32 | Current priority [31:24] and pending source [23:0] |
| ipi_prio | output | 8 | Stored IPI priority |
| acc_valid | output | 1 | Pulse: accept result valid |
| acc_word | output | 32 | Pending word returned by accept |
| rej_valid | output | 1 | Pulse: a source is handed back |
| rej_src | output | 24 | Rejected source number |
| resend_req | output | 1 | Pulse: source unit should replay held interrupts |
| eoi_valid | output | 1 | Pulse: end-of-interrupt toward source unit |
| eoi_src | output | 24 | Source number of the end-of-interrupt |

## Verification
The bench targets the equality edges of the comparisons:
- An offer whose priority equals the current priority must be refused. An off-by-one compare would accept it.
- An offer whose priority equals the pending priority must bounce the newcomer, not the incumbent.
- A current priority lowered exactly to the pending priority must clear that source. Lowering it to a value still above the pending priority must keep the source.

The IPI paths are tested in three ways: with the check blocked by a more favoured pending source, with the check displacing a source, and with the check triggered from a raise of the current priority. A design that skips the IPI check on resend would leave the line low. The bench also confirms that end-of-interrupt with a source still pending sends no resend.

// File: rtl/cpu_irq_presenter.sv
module cpu_irq_presenter #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              cmd_op,
  input  logic [SRC_W+PRIO_W-1:0] cmd_data,
  output logic                    irq_out,
  output logic [SRC_W+PRIO_W-1:0] pend_word,
  output logic [PRIO_W-1:0]       ipi_prio,
  output logic                    acc_valid,
  output logic [SRC_W+PRIO_W-1:0] acc_word,
  output logic                    rej_valid,
  output logic [SRC_W-1:0]        rej_src,
  output logic                    resend_req,
  output logic                    eoi_valid,
  output logic [SRC_W-1:0]        eoi_src
);
  localparam int WORD_W = SRC_W + PRIO_W;
  localparam logic [PRIO_W-1:0] LEAST = '1;
  localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);
  localparam logic [2:0] OP_OFFER = 3'd1, OP_CUR = 3'd2, OP_IPI = 3'd3,
                         OP_ACC = 3'd4, OP_EOI = 3'd5;

  logic [PRIO_W-1:0] cur_q, cur_n, pprio_q, pprio_n, ipi_q, ipi_n, chk_prio;
  logic [SRC_W-1:0]  src_q, src_n, rej_s, eoi_s;
  logic              irq_q, irq_n, chk_en, rej_v, rsd_v, eoi_v, acc_v;
  logic [WORD_W-1:0] acc_n;

  wire [PRIO_W-1:0] in_lo  = cmd_data[PRIO_W-1:0];
  wire [PRIO_W-1:0] in_hi  = cmd_data[WORD_W-1:SRC_W];
  wire [SRC_W-1:0]  in_src = cmd_data[SRC_W-1:0];
  wire              busy   = src_q != '0;

  always_comb begin
    cur_n = cur_q; src_n = src_q; pprio_n = pprio_q; ipi_n = ipi_q; irq_n = irq_q;
    acc_n = acc_word; acc_v = 1'b0;
    rej_v = 1'b0; rej_s = '0; rsd_v = 1'b0; eoi_v = 1'b0; eoi_s = '0;
    chk_en = 1'b0; chk_prio = ipi_q;
    case (cmd_op)
      OP_OFFER: begin
        if (in_hi >= cur_q || (busy && pprio_q <= in_hi)) begin
          rej_v = 1'b1; rej_s = in_src;
        end else begin
          if (busy) begin rej_v = 1'b1; rej_s = src_q; end
          src_n = in_src; pprio_n = in_hi; irq_n = 1'b1;
        end
      end
      OP_IPI: begin
        ipi_n = in_lo;
        chk_prio = in_lo;
        chk_en = in_lo < cur_q;
      end
      OP_CUR: begin
        cur_n = in_lo;
        if (in_lo < cur_q) begin
          if (busy && in_lo <= pprio_q) begin
            rej_v = 1'b1; rej_s = src_q;
            src_n = '0; pprio_n = LEAST; irq_n = 1'b0;
          end
        end else if (!busy) begin
          rsd_v = 1'b1;
          chk_en = ipi_q < in_lo;
        end
      end
      OP_ACC: begin
        acc_v = 1'b1; acc_n = {cur_q, src_q};
        irq_n = 1'b0; cur_n = pprio_q; src_n = '0; pprio_n = LEAST;
      end
      OP_EOI: begin
        cur_n = in_hi; eoi_v = 1'b1; eoi_s = in_src;
        if (!busy) begin
          rsd_v = 1'b1;
          chk_en = ipi_q < in_hi;
        end
      end
      default: ;
    endcase
    if (chk_en && !(src_n != '0 && pprio_n <= chk_prio)) begin
      if (src_n != '0) begin rej_v = 1'b1; rej_s = src_n; end
      src_n = IPI_NUM; pprio_n = chk_prio; irq_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0; src_q <= '0; pprio_q <= LEAST; ipi_q <= LEAST; irq_q <= 1'b0;
      acc_valid <= 1'b0; acc_word <= '0; rej_valid <= 1'b0; rej_src <= '0;
      resend_req <= 1'b0; eoi_valid <= 1'b0; eoi_src <= '0;
    end else begin
      cur_q <= cur_n; src_q <= src_n; pprio_q <= pprio_n; ipi_q <= ipi_n; irq_q <= irq_n;
      acc_valid <= acc_v; acc_word <= acc_n; rej_valid <= rej_v; rej_src <= rej_s;
      resend_req <= rsd_v; eoi_valid <= eoi_v; eoi_src <= eoi_s;
    end
  end

  assign irq_out   = irq_q;
  assign pend_word = {cur_q, src_q};
  assign ipi_prio  = ipi_q;
endmodule

// File: rtl/cpu_irq_presenter_chk.sv
module cpu_irq_presenter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  cmd_op,
  input logic [31:0] cmd_data,
  input logic        irq_out,
  input logic [31:0] pend_word,
  input logic [7:0]  ipi_prio,
  input logic        rej_valid,
  input logic [23:0] rej_src,
  input logic        resend_req,
  input logic        eoi_valid,
  input logic [23:0] eoi_src
);
  p_line_has_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> pend_word[23:0] != 24'd0);

  p_refuse_low_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd1 && cmd_data[31:24] >= pend_word[31:24])
      |=> rej_valid && rej_src == $past(cmd_data[23:0]));

  p_ipi_stored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == 3'd3 |=> ipi_prio == $past(cmd_data[7:0]));

  p_accept_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == 3'd4 |=> !irq_out && pend_word[23:0] == 24'd0);

  p_eoi_forward_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == 3'd5 |=> eoi_valid && eoi_src == $past(cmd_data[23:0])
                       && pend_word[31:24] == $past(cmd_data[31:24]));

  p_resend_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resend_req |-> $past(cmd_op) == 3'd2 || $past(cmd_op) == 3'd5);
endmodule

bind cpu_irq_presenter cpu_irq_presenter_chk chk (
  .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_data(cmd_data),
  .irq_out(irq_out), .pend_word(pend_word), .ipi_prio(ipi_prio),
  .rej_valid(rej_valid), .rej_src(rej_src), .resend_req(resend_req),
  .eoi_valid(eoi_valid), .eoi_src(eoi_src)
);

// File: tb/cpu_irq_presenter_test.sv
module cpu_irq_presenter_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [31:0] cmd_data = '0;
  logic irq_out, acc_valid, rej_valid, resend_req, eoi_valid;
  logic [31:0] pend_word, acc_word;
  logic [7:0] ipi_prio;
  logic [23:0] rej_src, eoi_src;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  cpu_irq_presenter uut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .irq_out(irq_out), .pend_word(pend_word), .ipi_prio(ipi_prio),
    .acc_valid(acc_valid), .acc_word(acc_word), .rej_valid(rej_valid),
    .rej_src(rej_src), .resend_req(resend_req), .eoi_valid(eoi_valid),
    .eoi_src(eoi_src)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [31:0] d);
    @(negedge clk); cmd_op = op; cmd_data = d;
    @(negedge clk); cmd_op = 3'd0; cmd_data = '0;
  endtask

  task automatic expect_out(input string req, input logic [31:0] pw, input logic irq,
                            input logic rv, input logic [23:0] rs, input logic rsd);
    chk(req, "pend_word", pend_word, pw);
    chk(req, "irq_out", {31'd0, irq_out}, {31'd0, irq});
    chk(req, "rej_valid", {31'd0, rej_valid}, {31'd0, rv});
    if (rv) chk(req, "rej_src", {8'd0, rej_src}, {8'd0, rs});
    chk(req, "resend_req", {31'd0, resend_req}, {31'd0, rsd});
  endtask

  task automatic t_reset;
    chk("R1", "pend_word", pend_word, 32'h0);
    chk("R1", "ipi_prio", {24'd0, ipi_prio}, 32'hFF);
    chk("R1", "strobes", {27'd0, irq_out, rej_valid, resend_req, eoi_valid, acc_valid}, 32'h0);
  endtask

  task automatic t_refuse_current;
    issue(3'd1, 32'h05_000010);
    expect_out("R2", 32'h00_000000, 1'b0, 1'b1, 24'h10, 1'b0);
    issue(3'd2, 32'h80);
    expect_out("R9", 32'h80_000000, 1'b0, 1'b0, 24'h0, 1'b1);
    issue(3'd1, 32'h80_000011);
    expect_out("R2", 32'h80_000000, 1'b0, 1'b1, 24'h11, 1'b0);
  endtask

  task automatic t_offers;
    issue(3'd1, 32'h40_000020);
    expect_out("R4", 32'h80_000020, 1'b1, 1'b0, 24'h0, 1'b0);
    issue(3'd1, 32'h40_000030);
    expect_out("R3", 32'h80_000020, 1'b1, 1'b1, 24'h30, 1'b0);
    issue(3'd1, 32'h10_000031);
    expect_out("R4", 32'h80_000031, 1'b1, 1'b1, 24'h20, 1'b0);
  endtask

  task automatic t_accept_eoi;
    issue(3'd4, 32'h0);
    chk("R7", "acc_valid", {31'd0, acc_valid}, 32'h1);
    chk("R7", "acc_word", acc_word, 32'h80_000031);
    expect_out("R7", 32'h10_000000, 1'b0, 1'b0, 24'h0, 1'b0);
    issue(3'd5, 32'h80_000031);
    chk("R10", "eoi_valid", {31'd0, eoi_valid}, 32'h1);
    chk("R10", "eoi_src", {8'd0, eoi_src}, 32'h31);
    expect_out("R10", 32'h80_000000, 1'b0, 1'b0, 24'h0, 1'b1);
    @(negedge clk);
    chk("R11", "pulses dropped", {28'd0, rej_valid, resend_req, eoi_valid, acc_valid}, 32'h0);
  endtask

  task automatic t_ipi;
    issue(3'd3, 32'h50);
    chk("R5", "ipi_prio", {24'd0, ipi_prio}, 32'h50);
    expect_out("R5", 32'h80_000002, 1'b1, 1'b0, 24'h0, 1'b0);
    issue(3'd1, 32'h20_000040);
    expect_out("R4", 32'h80_000040, 1'b1, 1'b1, 24'h2, 1'b0);
    issue(3'd3, 32'h30);
    chk("R6", "ipi_prio", {24'd0, ipi_prio}, 32'h30);
    expect_out("R6", 32'h80_000040, 1'b1, 1'b0, 24'h0, 1'b0);
    issue(3'd3, 32'h10);
    expect_out("R5", 32'h80_000002, 1'b1, 1'b1, 24'h40, 1'b0);
  endtask

  task automatic t_current;
    issue(3'd2, 32'h10);
    expect_out("R8", 32'h10_000000, 1'b0, 1'b1, 24'h2, 1'b0);
    issue(3'd2, 32'h20);
    expect_out("R9", 32'h20_000002, 1'b1, 1'b0, 24'h0, 1'b1);
    issue(3'd2, 32'h18);
    expect_out("R8", 32'h18_000002, 1'b1, 1'b0, 24'h0, 1'b0);
    issue(3'd5, 32'hFF_000055);
    chk("R10", "eoi_src", {8'd0, eoi_src}, 32'h55);
    expect_out("R10", 32'hFF_000002, 1'b1, 1'b0, 24'h0, 1'b0);
    issue(3'd0, 32'h0);
    expect_out("R11", 32'hFF_000002, 1'b1, 1'b0, 24'h0, 1'b0);
    issue(3'd4, 32'h0);
    chk("R7", "acc_word", acc_word, 32'hFF_000002);
    expect_out("R7", 32'h10_000000, 1'b0, 1'b0, 24'h0, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_refuse_current();
        t_offers();
        t_accept_eoi();
        t_ipi();
        t_current();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule